// File: doc/BRIEF.md
# Byte Run-Length Expander

This block sits on a byte stream that carries run-length compressed data and restores the original bytes. Only two byte values are treated as compressible: the all-zero byte and the all-one byte. Whenever one of them appears in the compressed stream, the byte after it is read as a repeat count. The block then emits the fill value that many times, whole bytes only, and nothing is carried between bit positions. Any other byte is a literal and passes through as a single copy.

Both sides use valid/ready handshakes. A literal is forwarded in the cycle it arrives, so the input ready follows the output ready. While a run is being emitted, the input is held off. A separate end-of-stream strobe marks the end of the compressed data. If that strobe arrives after a fill byte but before its count, the block raises a format-error flag that stays set until reset.

Top module: `rlx_expander`

## Requirements
- R1: A byte other than 0x00 and 0xFF, accepted while the block waits for a token, appears on the output unchanged, exactly once, in the same cycle it is accepted (input ready equals output ready for it).
- R2: A 0x00 or 0xFF byte is never output as itself. The byte accepted after it is an unsigned count c, and the block then outputs exactly c copies of that same fill byte before it accepts anything else.
- R3: A count of 1 after a fill byte yields exactly one output byte equal to the fill byte.
- R4: A count of 0 after a fill byte yields no output byte, and the next accepted byte is treated as a new token.
- R5: While copies of a run remain to be output, input ready is low and output valid is high.
- R6: The remaining copy count drops only on an output handshake. While output ready is low during a run, the output data holds and valid stays high.
- R7: A high end-of-stream input while the block waits for a count byte sets the format-error flag on the next clock edge. The pending token is dropped, and the next byte is handled as a new token. The flag stays high until reset.
- R8: A high end-of-stream input while the block waits for a token or emits a run has no effect on the error flag or the output.
- R9: A synchronous active-high reset holds output valid and input ready low while it is applied. It clears the error flag and any pending run, and it leaves the block waiting for a token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Compressed byte available |
| in_ready | output | 1 | Block accepts the compressed byte this cycle |
| in_data | input | DATA_W | Compressed byte |
| stream_end | input | 1 | End-of-stream strobe |
| out_valid | output | 1 | Expanded byte available |
| out_ready | input | 1 | Consumer accepts the expanded byte |
| out_data | output | DATA_W | Expanded byte |
| fmt_err | output | 1 | Sticky error: the stream ended between a fill byte and its count |

## Verification
The hardest condition to reach from the ports is a consumer stall that falls inside a run, together with an end-of-stream strobe that lands exactly in the one-cycle gap between a fill byte and its count. Random valid and ready patterns, with a reproducible seed, drive long mixed streams of literals and runs with counts 0 to 6. These streams stall the output in the middle of runs many times. The bench keeps its own record of whether a count byte is pending, so it can raise end-of-stream in every other state at will. A directed sequence then hits the pending-count window precisely, and further directed cases apply reset in the middle of a run.

// File: rtl/rlx_pkg.sv
package rlx_pkg;

   typedef enum logic [1:0] {
      RLX_TOKEN = 2'd0,
      RLX_COUNT = 2'd1,
      RLX_RUN   = 2'd2
   } rlx_state_e;

endpackage

// File: rtl/rlx_classify.sv
// Decodes one byte: fill code (all zeros or all ones) and zero value.
module rlx_classify #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   output logic              escape_o,
   output logic              fill_one_o,
   output logic              zero_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rlx_classify: DATA_W must be at least 2");
      end
   endgenerate

   logic all_zero;
   logic all_one;

   assign all_zero   = ~|byte_i;
   assign all_one    = &byte_i;
   assign escape_o   = all_zero | all_one;
   assign fill_one_o = all_one;
   assign zero_o     = all_zero;

endmodule

// File: rtl/rlx_run_counter.sv
// Holds the number of run copies still to be emitted.
module rlx_run_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic             busy_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("rlx_run_counter: CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= load_val_i;
      end else if (step_i) begin
         remain_q <= remain_q - ONE;
      end
   end

   assign busy_o = (remain_q != '0);
   assign last_o = (remain_q == ONE);

   AST_STEP_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
      step_i |-> busy_o); // R6
   AST_LOAD_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      load_i |-> !busy_o); // R5

endmodule

// File: rtl/rlx_ctrl.sv
// Token sequencer: literal pass-through, fill/count capture, run emission, error flag.
module rlx_ctrl
   import rlx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_escape_i,
   input  logic              in_fill_one_i,
   input  logic              in_zero_i,
   input  logic              stream_end_i,
   input  logic              out_ready_i,
   input  logic              cnt_last_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              cnt_load_o,
   output logic              cnt_step_o,
   output logic              err_o
);

   rlx_state_e state_q;
   rlx_state_e state_d;
   logic       fill_q;
   logic       err_q;

   always_comb begin
      state_d     = state_q;
      in_ready_o  = 1'b0;
      out_valid_o = 1'b0;
      out_data_o  = in_data_i;
      cnt_load_o  = 1'b0;
      cnt_step_o  = 1'b0;
      if (!rst) begin
         case (state_q)
            RLX_TOKEN: begin
               if (in_escape_i) begin
                  in_ready_o = 1'b1;
                  if (in_valid_i) state_d = RLX_COUNT;
               end else begin
                  in_ready_o  = out_ready_i;
                  out_valid_o = in_valid_i;
               end
            end
            RLX_COUNT: begin
               if (stream_end_i) begin
                  state_d = RLX_TOKEN;
               end else begin
                  in_ready_o = 1'b1;
                  if (in_valid_i) begin
                     if (in_zero_i) begin
                        state_d = RLX_TOKEN;
                     end else begin
                        cnt_load_o = 1'b1;
                        state_d    = RLX_RUN;
                     end
                  end
               end
            end
            RLX_RUN: begin
               out_valid_o = 1'b1;
               out_data_o  = {DATA_W{fill_q}};
               if (out_ready_i) begin
                  cnt_step_o = 1'b1;
                  if (cnt_last_i) state_d = RLX_TOKEN;
               end
            end
            default: state_d = RLX_TOKEN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RLX_TOKEN;
         fill_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == RLX_TOKEN && in_valid_i && in_escape_i) begin
            fill_q <= in_fill_one_i;
         end
         if (state_q == RLX_COUNT && stream_end_i) begin
            err_q <= 1'b1;
         end
      end
   end

   assign err_o = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_q |=> err_q); // R7
   AST_RUN_HOLDS_ON_STALL: assert property (@(posedge clk) disable iff (rst)
      (state_q == RLX_RUN && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R6
   AST_END_OUTSIDE_COUNT: assert property (@(posedge clk) disable iff (rst)
      (state_q != RLX_COUNT && !err_q) |=> !err_q); // R8

endmodule

// File: rtl/rlx_expander.sv
// Byte run-length expander, top level.
module rlx_expander #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              stream_end,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              fmt_err
);

   localparam int CNT_W = DATA_W;

   logic in_escape;
   logic in_fill_one;
   logic in_zero;
   logic cnt_load;
   logic cnt_step;
   logic cnt_busy;
   logic cnt_last;

   rlx_classify #(.DATA_W(DATA_W)) u_classify (
      .byte_i     (in_data),
      .escape_o   (in_escape),
      .fill_one_o (in_fill_one),
      .zero_o     (in_zero)
   );

   rlx_run_counter #(.CNT_W(CNT_W)) u_counter (
      .clk        (clk),
      .rst        (rst),
      .load_i     (cnt_load),
      .load_val_i (in_data),
      .step_i     (cnt_step),
      .busy_o     (cnt_busy),
      .last_o     (cnt_last)
   );

   rlx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .in_valid_i    (in_valid),
      .in_data_i     (in_data),
      .in_escape_i   (in_escape),
      .in_fill_one_i (in_fill_one),
      .in_zero_i     (in_zero),
      .stream_end_i  (stream_end),
      .out_ready_i   (out_ready),
      .cnt_last_i    (cnt_last),
      .in_ready_o    (in_ready),
      .out_valid_o   (out_valid),
      .out_data_o    (out_data),
      .cnt_load_o    (cnt_load),
      .cnt_step_o    (cnt_step),
      .err_o         (fmt_err)
   );

   always_comb begin
      if (rst) begin
         AST_RESET_QUIET: assert (!out_valid && !in_ready); // R9
      end
   end

   AST_INPUT_BLOCKED_IN_RUN: assert property (@(posedge clk) disable iff (rst)
      cnt_busy |-> (!in_ready && out_valid)); // R5
   AST_LITERAL_ONLY_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !cnt_busy) |-> (out_data == in_data && !in_escape)); // R1
   AST_RUN_DATA_IS_FILL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && cnt_busy) |-> ((out_data == '0) || (out_data == '1))); // R2

endmodule

// File: tb/rlx_expander_bench.sv
`timescale 1ns/1ps
module rlx_expander_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_ready;
   logic [W-1:0] in_data;
   logic         stream_end;
   logic         out_valid;
   logic         out_ready;
   logic [W-1:0] out_data;
   logic         fmt_err;

   always #2 clk = ~clk;

   rlx_expander #(.DATA_W(W)) u_rlx_expander (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .stream_end(stream_end), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .fmt_err(fmt_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [W-1:0] stim[$];
   logic [W-1:0] expq[$];
   string        exptag[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   function automatic bit is_fill(input logic [W-1:0] b);
      return (b == '0) || (b == '1);
   endfunction

   function automatic string run_tag(input int c);
      if (c == 0) return "R4";
      if (c == 1) return "R3";
      return "R2";
   endfunction

   task automatic add_lit(input logic [W-1:0] v);
      stim.push_back(v);
      expq.push_back(v);
      exptag.push_back("R1");
   endtask

   task automatic add_run(input logic [W-1:0] f, input int c);
      stim.push_back(f);
      stim.push_back(W'(c));
      for (int k = 0; k < c; k++) begin
         expq.push_back(f);
         exptag.push_back(run_tag(c));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; stream_end = 1'b0; out_ready = 1'b0; in_data = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Plays the queued stream; vp/rp are valid/ready percentages, eos raises
   // stream_end whenever no count byte is pending.
   task automatic play(input int vp, input int rp, input bit eos);
      int idx = 0, eidx = 0, pending = 0;
      bit waiting = 0, hold_chk = 0;
      logic [W-1:0] hold_v = '0;
      for (int cyc = 0; cyc < 40000; cyc++) begin
         if (idx == stim.size() && eidx == expq.size() && pending == 0) break;
         @(negedge clk);
         in_valid   = (idx < stim.size()) && ($urandom_range(99) < vp);
         in_data    = (idx < stim.size()) ? stim[idx] : '0;
         out_ready  = ($urandom_range(99) < rp);
         stream_end = eos && !waiting && ($urandom_range(99) < 50);
         #1;
         if (hold_chk) chk(out_valid && out_data == hold_v, "R6 stall hold", out_data, hold_v);
         hold_chk = 0;
         if (pending > 0) begin
            chk(!in_ready, "R5 input ready in run", in_ready, 0);
            chk(out_valid, "R5 valid in run", out_valid, 1);
            if (!out_ready) begin hold_chk = 1; hold_v = out_data; end
         end
         if (out_valid && out_ready) begin
            if (eidx < expq.size())
               chk(out_data == expq[eidx], exptag[eidx], out_data, expq[eidx]);
            else
               chk(1'b0, "R2 extra output", out_data, 0);
            eidx++;
            if (pending > 0) pending--;
         end
         if (in_valid && in_ready) begin
            if (waiting) begin
               waiting = 0;
               pending = int'(in_data);
            end else if (is_fill(in_data)) begin
               waiting = 1;
            end
            idx++;
         end
      end
      chk(eidx == expq.size(), "R2 output byte count", eidx, expq.size());
      chk(idx == stim.size(), "R2 input consumed", idx, stim.size());
      if (eos) chk(!fmt_err, "R8 no error from end strobe", fmt_err, 0);
      @(negedge clk);
      in_valid = 1'b0; stream_end = 1'b0;
      stim.delete(); expq.delete(); exptag.delete();
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; in_valid = 1'b0; in_data = '0; stream_end = 1'b0; out_ready = 1'b0;
      // R9: quiet while in reset, even with a literal offered
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h33; out_ready = 1'b1;
      #1;
      chk(!out_valid, "R9 out_valid in reset", out_valid, 0);
      chk(!in_ready, "R9 in_ready in reset", in_ready, 0);
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;
      #1;
      chk(!fmt_err, "R9 error clear after reset", fmt_err, 0);
      chk(!out_valid, "R9 idle valid after reset", out_valid, 0);

      // Directed corner cases
      add_run(8'h00, 4);
      add_run(8'h00, 1);
      add_run(8'hFF, 3);
      add_run(8'h00, 0);
      add_lit(8'h7F);
      add_run(8'hFF, 0);
      add_lit(8'h01);
      add_lit(8'hFE);
      add_run(8'hFF, 1);
      add_run(8'h00, 255);
      add_lit(8'h80);
      play(100, 100, 1'b0);
      add_run(8'h00, 4);
      add_lit(8'h5A);
      add_run(8'hFF, 2);
      play(60, 30, 1'b0);

      // Random mixed streams
      for (int pass = 0; pass < 3; pass++) begin
         for (int t = 0; t < 400; t++) begin
            int sel = $urandom_range(9);
            if (sel < 4) add_lit(W'($urandom_range(254, 1)));
            else if (sel < 7) add_run(8'h00, $urandom_range(6));
            else add_run(8'hFF, $urandom_range(6));
         end
         play(pass == 0 ? 90 : 50, pass == 1 ? 90 : 40, pass == 2);
      end

      // R7: end strobe while a count byte is pending
      do_reset();
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h00; out_ready = 1'b1;
      #1;
      chk(in_ready && !out_valid, "R2 fill byte accepted silently", {in_ready, out_valid}, 2);
      @(negedge clk);
      in_valid = 1'b0; stream_end = 1'b1;
      @(negedge clk);
      stream_end = 1'b0;
      #1;
      chk(fmt_err, "R7 error set", fmt_err, 1);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h42;
      #1;
      chk(out_valid && out_data == 8'h42 && in_ready, "R7 next byte is new token", out_data, 8'h42);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(fmt_err, "R7 error sticky", fmt_err, 1);

      // R9: reset clears the error and a run in progress
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!fmt_err, "R9 error cleared", fmt_err, 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hFF;
      @(negedge clk);
      in_data = 8'h10;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      #1;
      chk(out_valid && out_data == 8'hFF, "R2 run started", out_data, 8'hFF);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!out_valid, "R9 run abandoned", out_valid, 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h55;
      #1;
      chk(out_valid && out_data == 8'h55, "R9 token state after reset", out_data, 8'h55);
      @(negedge clk);
      in_valid = 1'b0;

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule